// File: doc/BRIEF.md
# SPI Slave with Buffered Transmit

This block is the receiving end of a four-wire serial link. An external master drives the serial clock, the master-to-slave data line and an active-low select. The block returns data on the slave-to-master line and holds that line's output enable low whenever it is not selected. It accepts either clock idle level (polarity) and either sampling phase. All three link inputs are brought into the system clock domain through two-flop synchronisers, and their edges are found there. The system clock must run at least four times faster than the serial clock.

Transmit data is double-buffered. The host writes a byte into a holding register, and the engine copies it into its shift register only when a byte starts. Received bytes land in a read register that carries a full flag and an overrun flag. With phase 0, each byte needs its own falling edge on select, and that edge puts the MSB on the output before the first clock edge. With phase 1, bytes may follow one another while select stays low.

The engine is a three-state machine:
- `ST_IDLE` means released and waiting. The transition `start` (select falls) moves it to `ST_SHIFT`.
- `ST_SHIFT` moves bits. The transition `abort` (select rises early) returns it to `ST_IDLE`. The transition `done_p0` (eighth sample with phase 0) moves it to `ST_HOLD`. The transition `next_p1` (eighth sample with phase 1) stays in `ST_SHIFT` and reloads the shift register.
- `ST_HOLD` ignores the clock. The transition `release` (select rises) returns it to `ST_IDLE`.

Top module: `spi_slave_buffered`

## Requirements
- R1: `miso_oe_o` is 1 only while a transfer is open, that is from the synchronised falling edge of select until its synchronised rising edge. While `miso_oe_o` is 0, `miso_o` is 0. After reset, `miso_oe_o` is 0.
- R2: With `cfg_cpha_i`=0, a falling edge on `sel_ni` places the MSB of the loaded byte on `miso_o` within 3 system clocks, before any serial clock edge.
- R3: Data moves MSB first, 8 bits per byte, in all four modes. The leading edge is the edge that leaves the idle level given by `cfg_cpol_i`. Phase 0 samples on leading edges and shifts on trailing edges. Phase 1 shifts on leading edges, except the first of each byte, and samples on trailing edges.
- R4: With `cfg_cpha_i`=0, serial clock edges after the eighth bit have no effect until select rises and falls again. No further byte is received.
- R5: The holding register is copied to the shift register only when a byte starts. A write made during a transfer is held and used for the next byte. `tx_empty_o` is 1 after reset, 0 after a write, and 1 again once the byte is taken.
- R6: If the holding register is empty when a byte starts, the byte sent is 8'hFF.
- R7: When the eighth bit is sampled, the byte goes to `rd_data_o` and `rx_full_o` is set. A pulse on `rd_en_i` clears `rx_full_o`.
- R8: If a byte completes while `rx_full_o` is set, `overrun_o` is set and `rd_data_o` keeps the old byte. A pulse on `rd_en_i` clears `overrun_o`.
- R9: If select rises before 8 bits, the partial byte is discarded and the bit count restarts at the next select fall.
- R10: With `cfg_cpha_i`=1 and select held low, the eighth sample ends the byte and immediately reloads the shift register from the holding register (8'hFF if it is empty).
- R11: After reset, `tx_empty_o`=1, `rx_full_o`=0 and `overrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data from the master |
| sel_ni | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data to the master (0 while released) |
| miso_oe_o | output | 1 | Output enable for `miso_o` |
| cfg_cpol_i | input | 1 | Serial clock idle level |
| cfg_cpha_i | input | 1 | Sampling phase |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | DATA_W | Byte to transmit |
| rd_en_i | input | 1 | Read strobe for the receive register; clears both flags |
| rd_data_o | output | DATA_W | Last received byte |
| tx_empty_o | output | 1 | Holding register can take a byte |
| rx_full_o | output | 1 | Receive register holds an unread byte |
| overrun_o | output | 1 | A byte arrived while the register was full |

## Verification
A wrong bit count or shift state shows up within one byte: the master collects a misordered or shifted byte on `miso_o`, and `rd_data_o` differs once select rises. A state machine stuck in or skipping `ST_HOLD` shows up as an extra received byte, or a missing one, a few system clocks after the eighth sample. A holding register copied at the wrong time shows up as the wrong byte in the first transfer after a mid-transfer write. Flag errors show up at the ports 3 to 4 system clocks after the closing serial clock edge.

// File: rtl/spis_pkg.sv
package spis_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2
    } spis_state_e;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int unsigned          WIDTH   = 3,
    parameter int unsigned          STAGES  = 2,
    parameter logic [WIDTH-1:0]     RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stage_q[g] <= RST_VAL;
            end else if (g == 0) begin
                stage_q[g] <= d_i;
            end else begin
                stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spis_edges.sv
module spis_edges (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sck_s_i,
    input  logic sel_n_s_i,
    input  logic cpol_i,
    input  logic cpha_i,
    output logic sample_ev_o,
    output logic shift_ev_o,
    output logic sel_fall_o,
    output logic sel_rise_o
);
    logic sck_d_q;
    logic sel_d_q;
    logic sck_rise;
    logic sck_fall;
    logic lead_ev;
    logic trail_ev;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sck_d_q <= 1'b0;
            sel_d_q <= 1'b1;
        end else begin
            sck_d_q <= sck_s_i;
            sel_d_q <= sel_n_s_i;
        end
    end

    always_comb begin
        sck_rise    = sck_s_i & ~sck_d_q;
        sck_fall    = ~sck_s_i & sck_d_q;
        lead_ev     = cpol_i ? sck_fall : sck_rise;
        trail_ev    = cpol_i ? sck_rise : sck_fall;
        sample_ev_o = cpha_i ? trail_ev : lead_ev;
        shift_ev_o  = cpha_i ? lead_ev  : trail_ev;
        sel_fall_o  = sel_d_q & ~sel_n_s_i;
        sel_rise_o  = ~sel_d_q & sel_n_s_i;
    end
endmodule

// File: rtl/spis_engine.sv
module spis_engine
    import spis_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cpha_i,
    input  logic              mosi_s_i,
    input  logic              sample_ev_i,
    input  logic              shift_ev_i,
    input  logic              sel_fall_i,
    input  logic              sel_rise_i,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic              tx_take_o,
    output logic              byte_done_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output spis_state_e       state_o
);
    localparam int unsigned     CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    spis_state_e       state_q, state_d;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              oe_q;
    logic              load;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Transitions and strobes
    always_comb begin
        state_d     = state_q;
        load        = 1'b0;
        byte_done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sel_fall_i) begin          // start
                    state_d = ST_SHIFT;
                    load    = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sel_rise_i) begin          // abort
                    state_d = ST_IDLE;
                end else if (sample_ev_i && cnt_q == LAST) begin
                    byte_done_o = 1'b1;
                    if (cpha_i) load = 1'b1;   // next_p1
                    else state_d = ST_HOLD;    // done_p0
                end
            end
            ST_HOLD: begin
                if (sel_rise_i) state_d = ST_IDLE;  // release
            end
            default: state_d = ST_IDLE;
        endcase
        tx_take_o = load & tx_valid_i;
    end

    // Datapath and outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_sh_q <= '1;
            rx_sh_q <= '0;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else begin
            oe_q <= (state_d != ST_IDLE);
            if (state_q == ST_SHIFT && sample_ev_i) begin
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], mosi_s_i};
            end
            if (load) begin
                tx_sh_q <= tx_valid_i ? tx_byte_i : '1;
                cnt_q   <= '0;
            end else if (state_q == ST_SHIFT && sel_rise_i) begin
                cnt_q   <= '0;
            end else if (state_q == ST_SHIFT) begin
                if (sample_ev_i) cnt_q <= cnt_q + 1'b1;
                if (shift_ev_i && cnt_q != '0) begin
                    tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
                end
            end
        end
    end

    assign rx_byte_o = {rx_sh_q[DATA_W-2:0], mosi_s_i};
    assign miso_oe_o = oe_q;
    assign miso_o    = oe_q & tx_sh_q[DATA_W-1];
    assign state_o   = state_q;
endmodule

// File: rtl/spis_hostregs.sv
module spis_hostregs #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic              tx_take_i,
    input  logic              byte_done_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_full_o,
    output logic              overrun_o
);
    logic [DATA_W-1:0] tx_q;
    logic              txv_q;
    logic [DATA_W-1:0] rx_q;
    logic              full_q;
    logic              ovr_q;
    logic              full_d;
    logic              ovr_d;
    logic              capture;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_q  <= '0;
            txv_q <= 1'b0;
        end else if (wr_en_i) begin
            tx_q  <= wr_data_i;
            txv_q <= 1'b1;
        end else if (tx_take_i) begin
            txv_q <= 1'b0;
        end
    end

    always_comb begin
        full_d  = full_q & ~rd_en_i;
        ovr_d   = ovr_q & ~rd_en_i;
        capture = 1'b0;
        if (byte_done_i) begin
            if (full_d) begin
                ovr_d = 1'b1;
            end else begin
                full_d  = 1'b1;
                capture = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_q   <= '0;
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            full_q <= full_d;
            ovr_q  <= ovr_d;
            if (capture) rx_q <= rx_byte_i;
        end
    end

    assign tx_valid_o = txv_q;
    assign tx_byte_o  = tx_q;
    assign rx_data_o  = rx_q;
    assign rx_full_o  = full_q;
    assign overrun_o  = ovr_q;
endmodule

// File: rtl/spi_slave_buffered.sv
module spi_slave_buffered
    import spis_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              sel_ni,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              tx_empty_o,
    output logic              rx_full_o,
    output logic              overrun_o
);
    logic [2:0]        pins_s;
    logic              sample_ev, shift_ev, sel_fall_w, sel_rise_w;
    logic              tx_take_w, byte_done_w, tx_valid_w;
    logic [DATA_W-1:0] tx_byte_w, rx_byte_w;
    spis_state_e       state_w;

    spis_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .d_i({sel_ni, mosi_i, sck_i}), .q_o(pins_s)
    );

    spis_edges u_edges (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .sck_s_i(pins_s[0]), .sel_n_s_i(pins_s[2]),
        .cpol_i(cfg_cpol_i), .cpha_i(cfg_cpha_i),
        .sample_ev_o(sample_ev), .shift_ev_o(shift_ev),
        .sel_fall_o(sel_fall_w), .sel_rise_o(sel_rise_w)
    );

    spis_engine #(.DATA_W(DATA_W)) u_engine (
        .clk_i(clk_i), .rst_ni(rst_ni), .cpha_i(cfg_cpha_i),
        .mosi_s_i(pins_s[1]), .sample_ev_i(sample_ev), .shift_ev_i(shift_ev),
        .sel_fall_i(sel_fall_w), .sel_rise_i(sel_rise_w),
        .tx_valid_i(tx_valid_w), .tx_byte_i(tx_byte_w),
        .tx_take_o(tx_take_w), .byte_done_o(byte_done_w), .rx_byte_o(rx_byte_w),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .state_o(state_w)
    );

    spis_hostregs #(.DATA_W(DATA_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .tx_take_i(tx_take_w), .byte_done_i(byte_done_w), .rx_byte_i(rx_byte_w),
        .tx_valid_o(tx_valid_w), .tx_byte_o(tx_byte_w),
        .rx_data_o(rd_data_o), .rx_full_o(rx_full_o), .overrun_o(overrun_o)
    );

    assign tx_empty_o = ~tx_valid_w;
endmodule

// File: rtl/spis_checker.sv
module spis_checker
    import spis_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic              cfg_cpha_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              tx_empty_o,
    input logic              rx_full_o,
    input logic              overrun_o,
    input logic              tx_take_w,
    input logic              byte_done_w,
    input logic              sel_fall_w,
    input spis_state_e       state_w
);
    p_released_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !miso_oe_o |-> !miso_o);

    p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_IDLE && $past(state_w) == ST_IDLE) |-> !miso_oe_o);

    p_hold_no_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_HOLD) |-> !byte_done_w);

    p_take_at_start_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_take_w |-> (sel_fall_w || (byte_done_w && cfg_cpha_i)));

    p_empty_after_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_take_w && !wr_en_i) |=> tx_empty_o);

    p_full_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (byte_done_w && !rx_full_o) |=> rx_full_o);

    p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_en_i && !byte_done_w) |=> (!rx_full_o && !overrun_o));

    p_overrun_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_full_o && byte_done_w && !rd_en_i) |=> (overrun_o && $stable(rd_data_o)));
endmodule

bind spi_slave_buffered spis_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .miso_o(miso_o), .miso_oe_o(miso_oe_o),
    .cfg_cpha_i(cfg_cpha_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .rd_data_o(rd_data_o), .tx_empty_o(tx_empty_o), .rx_full_o(rx_full_o),
    .overrun_o(overrun_o), .tx_take_w(tx_take_w), .byte_done_w(byte_done_w),
    .sel_fall_w(sel_fall_w), .state_w(state_w)
);

// File: tb/tb_spi_slave_buffered.sv
module tb_spi_slave_buffered;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, sel_n = 1'b1;
    logic       cpol = 1'b0, cpha = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       miso, miso_oe, tx_empty, rx_full, overrun;
    logic [7:0] rd_data;
    logic [7:0] got;
    logic [7:0] rbyte;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    spi_slave_buffered dut (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .sel_ni(sel_n),
        .miso_o(miso), .miso_oe_o(miso_oe), .cfg_cpol_i(cpol), .cfg_cpha_i(cpha),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .tx_empty_o(tx_empty), .rx_full_o(rx_full), .overrun_o(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        @(negedge clk);
        sck = pol; cpol = pol; cpha = pha;
        tick(HALF);
    endtask

    task automatic host_write(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk); rbyte = rd_data; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic sel_low();
        @(negedge clk); sel_n = 1'b0; got = '0;
        tick(HALF);
    endtask

    task automatic sel_high();
        @(negedge clk); sel_n = 1'b1;
        tick(HALF);
    endtask

    // Master side: sends bits first..first+n-1 of mo, collects MISO into got
    task automatic xfer(input logic [7:0] mo, input int first, input int n);
        for (int i = first; i < first + n; i++) begin
            if (!cpha) begin
                mosi = mo[7-i];
                tick(HALF);
                got = {got[6:0], miso};
                sck = ~cpol;
                tick(HALF);
                sck = cpol;
            end else begin
                sck = ~cpol;
                mosi = mo[7-i];
                tick(HALF);
                got = {got[6:0], miso};
                sck = cpol;
                tick(HALF);
            end
        end
        tick(HALF);
    endtask

    task automatic t_reset();
        chk("R11 tx_empty", tx_empty, 1);
        chk("R11 rx_full", rx_full, 0);
        chk("R11 overrun", overrun, 0);
        chk("R1 oe after reset", miso_oe, 0);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic [7:0] tb_, input logic [7:0] rb);
        set_mode(pol, pha);
        host_write(tb_);
        chk("R5 tx_empty after write", tx_empty, 0);
        chk("R1 released before select", miso_oe, 0);
        sel_low();
        chk("R1 driven while selected", miso_oe, 1);
        chk("R5 tx taken at start", tx_empty, 1);
        if (!pha) chk("R2 MSB before first edge", miso, tb_[7]);
        xfer(rb, 0, 8);
        chk("R3 miso byte", got, tb_);
        sel_high();
        chk("R1 released after select", miso_oe, 0);
        chk("R1 miso low when released", miso, 0);
        chk("R7 rx_full set", rx_full, 1);
        chk("R7 rx data", rd_data, rb);
        host_read();
        chk("R7 rx_full cleared", rx_full, 0);
    endtask

    task automatic t_held_r5();
        set_mode(1'b0, 1'b0);
        host_write(8'hA3);
        sel_low();
        xfer(8'h00, 0, 3);
        host_write(8'h5C);
        chk("R5 write held during transfer", tx_empty, 0);
        xfer(8'h00, 3, 5);
        chk("R5 current byte unaffected", got, 8'hA3);
        sel_high();
        host_read();
        sel_low();
        chk("R5 held byte taken", tx_empty, 1);
        xfer(8'h00, 0, 8);
        chk("R5 held byte sent next", got, 8'h5C);
        sel_high();
        host_read();
    endtask

    task automatic t_hold_r4();
        set_mode(1'b1, 1'b0);
        host_write(8'h96);
        sel_low();
        xfer(8'hC1, 0, 8);
        chk("R4 first byte", rd_data, 8'hC1);
        host_read();
        xfer(8'h5A, 0, 8);
        chk("R4 no second byte without select", rx_full, 0);
        chk("R4 rx data unchanged", rd_data, 8'hC1);
        sel_high();
        chk("R4 no byte at release", rx_full, 0);
    endtask

    task automatic t_empty_r6();
        set_mode(1'b0, 1'b0);
        sel_low();
        xfer(8'h24, 0, 8);
        chk("R6 all ones when empty", got, 8'hFF);
        sel_high();
        host_read();
    endtask

    task automatic t_abort_r9();
        set_mode(1'b0, 1'b1);
        host_write(8'h3E);
        sel_low();
        xfer(8'hF0, 0, 4);
        sel_high();
        chk("R9 partial byte discarded", rx_full, 0);
        sel_low();
        xfer(8'h3C, 0, 8);
        chk("R9 after abort tx empty sends ones", got, 8'hFF);
        sel_high();
        chk("R9 full byte after abort", rd_data, 8'h3C);
        chk("R9 rx_full after abort", rx_full, 1);
        host_read();
    endtask

    task automatic t_overrun_r8();
        set_mode(1'b0, 1'b0);
        sel_low(); xfer(8'h11, 0, 8); sel_high();
        sel_low(); xfer(8'h22, 0, 8); sel_high();
        chk("R8 overrun set", overrun, 1);
        chk("R8 old data kept", rd_data, 8'h11);
        host_read();
        chk("R8 overrun cleared by read", overrun, 0);
        chk("R7 rx_full cleared by read", rx_full, 0);
    endtask

    task automatic t_stream_r10();
        set_mode(1'b0, 1'b1);
        host_write(8'hE7);
        sel_low();
        xfer(8'h81, 0, 4);
        host_write(8'h4D);
        xfer(8'h81, 4, 4);
        chk("R10 first byte out", got, 8'hE7);
        chk("R10 first byte in", rd_data, 8'h81);
        chk("R10 reload takes held byte", tx_empty, 1);
        host_read();
        got = '0;
        xfer(8'h42, 0, 8);
        chk("R10 second byte out", got, 8'h4D);
        chk("R10 second byte in", rd_data, 8'h42);
        sel_high();
        host_read();
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        t_reset();
        t_mode(1'b0, 1'b0, 8'hB4, 8'h6D);
        t_mode(1'b1, 1'b0, 8'h5A, 8'hC3);
        t_mode(1'b0, 1'b1, 8'h81, 8'h7E);
        t_mode(1'b1, 1'b1, 8'h2F, 8'hD0);
        t_held_r5();
        t_hold_r4();
        t_empty_r6();
        t_abort_r9();
        t_overrun_r8();
        t_stream_r10();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule